// File: doc/BRIEF.md
# Atomic Set/Clear/Toggle Register Bank

This block is a small bank of control registers behind a simple memory-mapped bus. The two highest address bits select one of four views of the same registers. Through the plain view a write stores the data as given. Through the other three views a write either inverts, sets or clears only the register bits that are 1 in the write data. Software can therefore change single bits in one bus write, without reading the register first and without racing another agent that does the same.

Writes narrower than a full word are not merged into the register. The lane that was written is copied across the whole word, and that word is then applied with the selected operation. This reproduces the silent corruption of the unwritten bits that such hardware shows, and no error is raised.

One register index is exempt from aliasing. At that index the operation bits are ignored and every write acts as a plain write. Reads return the current contents through any view, one cycle after the request, and change nothing.

Top module: `alias_reg_bank`

## Requirements
- R1: After reset every register reads as zero and the read-data output is zero.
- R2: Address bits [13:12] select the operation: 2'b00 plain write, 2'b01 toggle (XOR), 2'b10 set (OR), 2'b11 clear (AND-NOT). Address bits [4:2] select one of eight registers. All other address bits are ignored.
- R3: A full-word write (strobe 4'b1111) through the plain view replaces the addressed register with the write data.
- R4: A write through the toggle view inverts exactly those register bits whose write-data bit is 1.
- R5: A write through the set view makes the register the old value OR the write data.
- R6: A write through the clear view makes the register the old value AND the inverse of the write data.
- R7: A read through any view returns the addressed register on the read-data output in the cycle after the request and changes no register. A read and a write in the same cycle return the value from before the write.
- R8: Register index 7 is exempt from aliasing: every write to it acts as a plain write, whatever address bits [13:12] hold.
- R9: For a write whose strobe has exactly one bit set (bit n enables byte lane n, data bits [8n+7:8n]), that byte is copied into all four lanes and the full 32-bit word is applied with the selected operation.
- R10: For strobe 4'b0011 the low halfword, and for 4'b1100 the high halfword, is copied into both halves before the operation. For any other partial pattern that is not zero, the lowest enabled byte is copied into all four lanes.
- R11: A write with strobe 4'b0000 changes no register.
- R12: A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Byte address: operation bits, register index and ignored bits |
| bus_wdata | input | 32 | Write data or operation mask |
| bus_be | input | 4 | Byte-lane strobe for writes |
| bus_we | input | 1 | Write request, completes in the same cycle |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |

## Verification
A wrong register value stays in the bank and is visible only through a read. For that reason the bench reads the targeted register back, through a randomly chosen view, right after each write. A wrong value then shows on the read-data output two cycles after the faulty write. Damage to a neighbouring register is caught by full sweeps of all eight registers, held over long random runs. A wrong lane replication or operation decode produces a mismatch against the bench model on that same first readback.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;

    // Operation carried in the two top address bits
    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_XOR   = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } alias_op_e;

endpackage

// File: rtl/alias_decode.sv
module alias_decode
    import alias_bank_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int NUM_REGS    = 8,
    parameter int IDX_W       = $clog2(NUM_REGS),
    parameter logic [NUM_REGS-1:0] EXEMPT_MASK = 8'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output alias_op_e         op,
    output logic [IDX_W-1:0]  idx
);
    localparam int OP_LSB = ADDR_W - 2;

    alias_op_e raw_op;
    logic      exempt;
    logic      unused_addr_bits;

    always_comb begin
        raw_op = alias_op_e'(addr[ADDR_W-1:OP_LSB]);
        idx    = addr[IDX_W+1:2];
        exempt = EXEMPT_MASK[idx];
        // Exempt registers see every write as a plain write
        op     = exempt ? OP_WRITE : raw_op;
    end

    assign unused_addr_bits = ^{addr[OP_LSB-1:IDX_W+2], addr[1:0]};

endmodule

// File: rtl/lane_replicate.sv
module lane_replicate #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] data_out,
    output logic              any_lane
);
    localparam int HALVES = LANES / 2;
    localparam logic [LANES-1:0] PAIR = LANES'(2'b11);

    logic        full;
    logic        found;
    logic        half_hit;
    logic [7:0]  byte_v;
    logic [15:0] half_v;

    always_comb begin
        full     = &be;
        any_lane = |be;
        found    = 1'b0;
        byte_v   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (be[i] && !found) begin
                byte_v = data_in[8*i +: 8];
                found  = 1'b1;
            end
        end
        half_hit = 1'b0;
        half_v   = '0;
        for (int p = 0; p < HALVES; p++) begin
            if (be == (PAIR << (2*p))) begin
                half_v   = data_in[16*p +: 16];
                half_hit = 1'b1;
            end
        end
        if (full) begin
            data_out = data_in;
        end else if (half_hit) begin
            data_out = {HALVES{half_v}};
        end else begin
            data_out = {LANES{byte_v}};
        end
    end

    // A single-lane strobe must yield identical bytes on every lane
    always_comb begin
        if ($countones(be) == 1) begin
            p_byte_repl_r9: assert (data_out == {LANES{data_out[7:0]}});
        end
    end

endmodule

// File: rtl/reg_update_unit.sv
module reg_update_unit
    import alias_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alias_op_e         op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] new_val
);
    always_comb begin
        unique case (op)
            OP_WRITE: new_val = mask;
            OP_XOR:   new_val = old_val ^ mask;
            OP_SET:   new_val = old_val | mask;
            OP_CLEAR: new_val = old_val & ~mask;
            default:  new_val = old_val;
        endcase
    end

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
    import alias_bank_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0] EXEMPT_MASK = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic                bus_we,
    input  logic                bus_re,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]               rdata;
    } bank_state_t;

    bank_state_t       st_d, st_q;
    alias_op_e         op;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] eff_data;
    logic              lane_valid;
    logic [DATA_W-1:0] upd_val;
    logic              wr_fire;

    alias_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_REGS    (NUM_REGS),
        .IDX_W       (IDX_W),
        .EXEMPT_MASK (EXEMPT_MASK)
    ) u_decode (
        .addr (bus_addr),
        .op   (op),
        .idx  (idx)
    );

    lane_replicate #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_lanes (
        .data_in  (bus_wdata),
        .be       (bus_be),
        .data_out (eff_data),
        .any_lane (lane_valid)
    );

    reg_update_unit #(
        .DATA_W (DATA_W)
    ) u_update (
        .op      (op),
        .old_val (st_q.regs[idx]),
        .mask    (eff_data),
        .new_val (upd_val)
    );

    assign wr_fire = bus_we && lane_valid;

    always_comb begin
        st_d = st_q;
        if (bus_re) begin
            st_d.rdata = st_q.regs[idx];
        end
        if (wr_fire) begin
            st_d.regs[idx] = upd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    p_xor_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op == OP_XOR) |=>
            ((st_q.regs[$past(idx)] ^ $past(st_q.regs[idx])) == $past(eff_data)));

    p_set_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op == OP_SET) |=>
            ((st_q.regs[$past(idx)] & $past(eff_data)) == $past(eff_data)));

    p_clear_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op == OP_CLEAR) |=>
            ((st_q.regs[$past(idx)] & $past(eff_data)) == '0));

    p_read_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> (bus_rdata == $past(st_q.regs[idx])));

    p_exempt_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && EXEMPT_MASK[idx]) |=> (st_q.regs[$past(idx)] == $past(eff_data)));

    p_no_write_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(st_q.regs));

endmodule

// File: tb/alias_reg_bank_bench.sv
`timescale 1ns/1ps
module alias_reg_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] exp_q [8];

    always #2 clk = ~clk;

    alias_reg_bank u_alias_reg_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [13:0] mk_addr(input logic [1:0] op, input int idx,
                                            input logic [6:0] junk, input logic [1:0] low);
        return {op, junk, 3'(idx), low};
    endfunction

    function automatic logic [31:0] lanes(input logic [31:0] d, input logic [3:0] be);
        if (be == 4'hF) return d;
        if (be == 4'h3) return {2{d[15:0]}};
        if (be == 4'hC) return {2{d[31:16]}};
        for (int i = 0; i < 4; i++)
            if (be[i]) return {4{d[8*i +: 8]}};
        return d;
    endfunction

    function automatic logic [31:0] apply(input logic [1:0] op, input logic [31:0] o,
                                          input logic [31:0] m);
        case (op)
            2'b00:   return m;
            2'b01:   return o ^ m;
            2'b10:   return o | m;
            default: return o & ~m;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] op, input int idx, input logic [31:0] d,
                      input logic [3:0] be, input logic [6:0] junk = '0);
        @(negedge clk);
        bus_addr  = mk_addr(op, idx, junk, 2'b00);
        bus_wdata = d;
        bus_be    = be;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (be != 4'h0)
            exp_q[idx] = apply((idx == 7) ? 2'b00 : op, exp_q[idx], lanes(d, be));
    endtask

    task automatic rd(input logic [1:0] op, input int idx, input string req);
        @(negedge clk);
        bus_addr = mk_addr(op, idx, 7'h55, 2'b11);
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        check(req, bus_rdata, exp_q[idx]);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 8; i++) rd(2'(i), i, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) exp_q[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        sweep("R1 registers after reset");

        wr(2'b00, 0, 32'hA5A5_0F0F, 4'hF);
        rd(2'b00, 0, "R3 plain write");
        wr(2'b01, 0, 32'hFF00_00FF, 4'hF);
        rd(2'b10, 0, "R4 xor alias");
        wr(2'b10, 0, 32'h0000_F000, 4'hF);
        rd(2'b01, 0, "R5 set alias");
        wr(2'b11, 0, 32'h0F0F_FFFF, 4'hF);
        rd(2'b11, 0, "R6 clear alias");
        rd(2'b11, 0, "R7 read has no side effect");
        check("R6 clear exact value", exp_q[0], 32'h50A0_0000);

        wr(2'b00, 7, 32'h1234_5678, 4'hF);
        wr(2'b11, 7, 32'h0000_00FF, 4'hF);
        rd(2'b00, 7, "R8 exempt clear acts as plain");
        check("R8 exempt value", exp_q[7], 32'h0000_00FF);
        wr(2'b01, 7, 32'hFFFF_0000, 4'hF);
        rd(2'b01, 7, "R8 exempt xor acts as plain");

        wr(2'b00, 1, 32'h1122_3344, 4'h4);
        rd(2'b00, 1, "R9 byte lane 2 replicated");
        check("R9 byte value", exp_q[1], 32'h2222_2222);
        wr(2'b10, 1, 32'h0000_0080, 4'h1);
        rd(2'b00, 1, "R9 byte set alias");
        wr(2'b00, 2, 32'hBEEF_CAFE, 4'hC);
        rd(2'b00, 2, "R10 high halfword replicated");
        check("R10 half value", exp_q[2], 32'hBEEF_BEEF);
        wr(2'b00, 2, 32'h1122_3344, 4'hA);
        rd(2'b00, 2, "R10 odd strobe lowest byte");
        wr(2'b00, 2, 32'hFFFF_FFFF, 4'h0);
        rd(2'b00, 2, "R11 empty strobe ignored");
        sweep("R12 neighbours untouched");

        // Same-cycle read and write returns the pre-write value
        @(negedge clk);
        bus_addr  = mk_addr(2'b00, 3, '0, 2'b00);
        bus_wdata = 32'hDEAD_BEEF;
        bus_be    = 4'hF;
        bus_we    = 1'b1;
        bus_re    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
        check("R7 read during write gives old", bus_rdata, exp_q[3]);
        exp_q[3] = 32'hDEAD_BEEF;
        rd(2'b00, 3, "R7 write landed");

        for (int k = 0; k < 1500; k++) begin
            logic [3:0] be_pick [9] = '{4'hF, 4'hF, 4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'h6};
            logic [3:0] be = be_pick[$urandom_range(8)];
            int         idx = $urandom_range(7);
            if ($urandom_range(20) == 0) be = 4'h0;
            wr(2'($urandom), idx, $urandom, be, 7'($urandom));
            rd(2'($urandom), idx, "R2 random alias decode");
            if (k % 100 == 99) sweep("R12 random sweep");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule